// File: doc/BRIEF.md
# Second-Level Sub-Line Refill Controller

This block sits under a first-level cache and serves its line-fill requests. Each request carries a word address. The first-level line is four words, and the local line is sixteen words, so every local line holds four requester lines.

The block keeps a small direct-mapped store. Each entry has a tag, a valid bit and sixteen data words. On a hit it returns the addressed four-word sub-line in one beat of a four-word response bus, and memory is not touched. On a miss it makes a single whole-line request to memory and takes sixteen one-word beats into the entry. It marks the entry valid and then returns the sub-line the requester asked for. Only one request is in flight at a time. The sequence is idle, lookup, then either respond or fill followed by respond, then idle again.

Top module: `l2_refill_ctrl`

## Requirements
- R1: A synchronous reset invalidates every entry and leaves the block idle. After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0, so the first access to any line misses.
- R2: The word address splits into four fields, from the least significant bit upward. Bits [1:0] pick a word inside a sub-line and have no effect on the result. Bits [3:2] pick one of the four sub-lines. The next log2(SETS) bits pick the entry. The remaining upper bits form the tag.
- R3: On a hit, exactly one response beat is produced and no memory request is made. In that beat, bits [32k+31:32k] of `rsp_data` hold word 4*s+k of the stored line, where s is the sub-line field.
- R4: On a miss, exactly one memory request is made. It carries the line base address, which is the request address with bits [3:0] cleared.
- R5: After the memory request is accepted, the n-th `mem_rd_valid` beat (counting from 0) is stored as word n of the line. Cycles without `mem_rd_valid` are skipped.
- R6: During a fill the target entry is not valid. It becomes valid with the new tag only after the sixteenth beat. Then the requested sub-line of the new data is returned, and later accesses to any sub-line of that line hit.
- R7: `req_ready` is high only while idle. Once a request is taken, it stays low until that request's response has been accepted.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold their values.
- R9: A request whose entry holds a different tag misses. It replaces that entry, so a later request to the evicted line misses again.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid` and `mem_req_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Fill request present |
| req_ready | output | 1 | Block can take a request (idle) |
| req_addr | input | ADDR_W | Word address of the request |
| rsp_valid | output | 1 | Response sub-line present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | SUB_WORDS*WORD_W | Four-word sub-line, word 0 in the low bits |
| mem_req_valid | output | 1 | Whole-line memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | ADDR_W | Line base word address |
| mem_rd_valid | input | 1 | One burst word present |
| mem_rd_data | input | WORD_W | Burst word |

## Verification
The bench builds the block with a 12-bit address and four entries. With so few entries, the same index is reached with many different tags, and conflict evictions and re-misses come up within a few dozen requests. Sixteen-word lines and 32-bit words are kept, so the sub-line select and the burst length are checked at their real sizes. The memory model inserts a stall before taking each request and gaps inside the burst. The requester holds back `rsp_ready` for varying numbers of cycles, which exercises the hold rules on both handshakes.

// File: rtl/l2_refill_ctrl.sv
module l2_refill_ctrl #(
  parameter int WORD_W     = 32,
  parameter int ADDR_W     = 16,
  parameter int SUB_WORDS  = 4,
  parameter int LINE_WORDS = 16,
  parameter int SETS       = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [ADDR_W-1:0]           req_addr,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [SUB_WORDS*WORD_W-1:0] rsp_data,
  output logic                        mem_req_valid,
  input  logic                        mem_req_ready,
  output logic [ADDR_W-1:0]           mem_req_addr,
  input  logic                        mem_rd_valid,
  input  logic [WORD_W-1:0]           mem_rd_data
);
  localparam int WSEL_W = $clog2(SUB_WORDS);
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int DEPTH  = SETS * LINE_WORDS;
  localparam int DA_W   = $clog2(DEPTH);
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_WORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOOKUP, S_FILL, S_RESP} state_t;

  state_t                   st_q;
  logic [ADDR_W-1:WSEL_W]   addr_q;
  logic [SETS-1:0]          valid_q;
  logic [TAG_W-1:0]         tag_q  [SETS];
  logic [WORD_W-1:0]        data_q [DEPTH];
  logic [OFF_W-1:0]         beat_q;
  logic                     issued_q;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             hit;
  logic             beat_in;
  logic             unused_low;

  assign idx        = addr_q[OFF_W +: IDX_W];
  assign tag        = addr_q[ADDR_W-1 -: TAG_W];
  assign hit        = valid_q[idx] && (tag_q[idx] == tag);
  assign beat_in    = (st_q == S_FILL) && issued_q && mem_rd_valid;
  assign unused_low = ^req_addr[WSEL_W-1:0];

  assign req_ready     = (st_q == S_IDLE);
  assign rsp_valid     = (st_q == S_RESP);
  assign mem_req_valid = (st_q == S_FILL) && !issued_q;
  assign mem_req_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  for (genvar k = 0; k < SUB_WORDS; k++) begin : g_rsp
    localparam logic [WSEL_W-1:0] KW = WSEL_W'(k);
    logic [DA_W-1:0] rd_a;
    assign rd_a = {addr_q[OFF_W+IDX_W-1:WSEL_W], KW};
    assign rsp_data[k*WORD_W +: WORD_W] = data_q[rd_a];
  end

  always_ff @(posedge clk) begin
    if (beat_in) data_q[{idx, beat_q}] <= mem_rd_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      addr_q   <= '0;
      valid_q  <= '0;
      beat_q   <= '0;
      issued_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr[ADDR_W-1:WSEL_W];
          st_q   <= S_LOOKUP;
        end
        S_LOOKUP: begin
          if (hit) st_q <= S_RESP;
          else begin
            valid_q[idx] <= 1'b0;
            beat_q       <= '0;
            issued_q     <= 1'b0;
            st_q         <= S_FILL;
          end
        end
        S_FILL: begin
          if (mem_req_valid && mem_req_ready) issued_q <= 1'b1;
          if (beat_in) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == LAST_BEAT) begin
              valid_q[idx] <= 1'b1;
              tag_q[idx]   <= tag;
              st_q         <= S_RESP;
            end
          end
        end
        default: if (rsp_ready) st_q <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_EXCL: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!rsp_valid && !mem_req_valid)); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R8
  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10
  AST_MEMREQ_ALIGN: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0)); // R4
  AST_FILL_INVALID: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_FILL) |-> !valid_q[idx]); // R6
  AST_FILL_DONE: assert property (@(posedge clk) disable iff (rst)
    (beat_in && beat_q == LAST_BEAT) |=> (valid_q[idx] && rsp_valid)); // R6
  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_LOOKUP && hit) |=> (rsp_valid && !mem_req_valid)); // R3
endmodule

// File: tb/test_l2_refill_ctrl.sv
`timescale 1ns/1ps
module test_l2_refill_ctrl;
  localparam int WORD_W = 32, ADDR_W = 12, SUB_WORDS = 4, LINE_WORDS = 16, SETS = 4;
  localparam int RW = SUB_WORDS * WORD_W;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic rsp_valid, rsp_ready = 0;
  logic [RW-1:0] rsp_data;
  logic mem_req_valid, mem_req_ready = 0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic mem_rd_valid = 0;
  logic [WORD_W-1:0] mem_rd_data = '0;

  always #2.5 clk = ~clk;

  l2_refill_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SUB_WORDS(SUB_WORDS),
                   .LINE_WORDS(LINE_WORDS), .SETS(SETS)) i_l2_refill_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data));

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [RW-1:0]     data;
    bit                miss;
    bit                conflict;
  } item_t;

  item_t sb[$];
  int checks = 0, errors = 0, mem_reqs = 0, resp_cnt = 0;
  logic [ADDR_W-1:0] mem_last_base = '0;
  bit m_valid[SETS];
  logic [5:0] m_tag[SETS];
  bit done = 0;

  function automatic logic [WORD_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return {8'h5A, a, 12'(a * 7)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [ADDR_W-1:0] a);
    item_t it;
    logic [ADDR_W-1:0] base;
    int ix = int'(a[5:4]);
    base = {a[ADDR_W-1:2], 2'b00};
    it.addr = a;
    it.miss = !(m_valid[ix] && m_tag[ix] == a[11:6]);
    it.conflict = m_valid[ix] && m_tag[ix] != a[11:6];
    m_valid[ix] = 1;
    m_tag[ix] = a[11:6];
    for (int k = 0; k < SUB_WORDS; k++) it.data[k*WORD_W +: WORD_W] = mem_word(base + ADDR_W'(k));
    sb.push_back(it);
    do @(negedge clk); while (!req_ready);
    req_valid = 1;
    req_addr = a;
    @(negedge clk);
    req_valid = 0;
    req_addr = ~a;
    chk(req_ready == 0, "R7", "ready after accept", RW'(req_ready), '0);
  endtask

  // memory model
  initial begin
    int stall = 0;
    logic [ADDR_W-1:0] base;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        if (stall < 2) begin
          if (stall > 0) chk(mem_req_addr == base, "R10", "mem addr held", RW'(mem_req_addr), RW'(base));
          base = mem_req_addr;
          stall++;
        end else begin
          chk(mem_req_valid && mem_req_addr == base, "R10", "mem req held", RW'(mem_req_addr), RW'(base));
          mem_req_ready = 1;
          @(negedge clk);
          mem_req_ready = 0;
          stall = 0;
          mem_reqs++;
          mem_last_base = base;
          for (int b = 0; b < LINE_WORDS; b++) begin
            if (b % 5 == 3) begin
              mem_rd_valid = 0;
              mem_rd_data = 32'hDEAD_BEEF;
              @(negedge clk);
            end
            mem_rd_valid = 1;
            mem_rd_data = mem_word(base + ADDR_W'(b));
            @(negedge clk);
          end
          mem_rd_valid = 0;
        end
      end
    end
  end

  // scoreboard monitor
  initial begin
    int prev = 0;
    logic [RW-1:0] snap;
    item_t it;
    string tagn;
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        snap = rsp_data;
        repeat (resp_cnt % 3) begin
          @(negedge clk);
          chk(rsp_valid && rsp_data == snap, "R8", "held under backpressure", rsp_data, snap);
        end
        rsp_ready = 1;
        if (sb.size() == 0) chk(0, "R3", "unexpected response", rsp_data, '0);
        else begin
          it = sb.pop_front();
          tagn = it.miss ? (it.conflict ? "R9 R5 R6" : "R5 R6") : "R3 R2";
          chk(rsp_data == it.data, tagn, "sub-line data", rsp_data, it.data);
          chk(mem_reqs - prev == (it.miss ? 1 : 0), it.miss ? "R4" : "R3", "memory requests",
              RW'(mem_reqs - prev), RW'(it.miss));
          if (it.miss)
            chk(mem_last_base == {it.addr[ADDR_W-1:4], 4'h0}, "R4", "line base", RW'(mem_last_base),
                RW'({it.addr[ADDR_W-1:4], 4'h0}));
        end
        prev = mem_reqs;
        resp_cnt++;
        @(negedge clk);
        rsp_ready = 0;
        chk(rsp_valid == 0, "R7", "single response beat", RW'(rsp_valid), '0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < SETS; i++) begin m_valid[i] = 0; m_tag[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk(req_ready == 1, "R1", "req_ready after reset", RW'(req_ready), RW'(1));
    chk(rsp_valid == 0, "R1", "rsp_valid after reset", RW'(rsp_valid), '0);
    chk(mem_req_valid == 0, "R1", "mem_req_valid after reset", RW'(mem_req_valid), '0);
    issue(12'h040);   // R1 first access misses
    issue(12'h04D);   // R2 word bits ignored, sub-line 3 hits
    issue(12'h046);
    issue(12'h0C8);   // R9 conflict on entry 0
    issue(12'h040);   // R9 evicted line misses again
    issue(12'h7F4);
    issue(12'h7FB);
    issue(12'h010);
    issue(12'h01C);
    issue(12'h020);
    issue(12'h03F);   // R9 conflict on entry 3
    issue(12'h7F0);
    for (int i = 0; i < 24; i++) issue(ADDR_W'((i * 37 + 5) % 256));
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(mem_req_valid == 0 && req_ready == 1, "R7", "idle at end", RW'(req_ready), RW'(1));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule